// File: doc/BRIEF.md
# PCM Transmit Serializer with Frame Sync Classification

This block sends one signed 13-bit sample per frame as a serial word on a pin that can be released to high impedance. The word is timed by an external bit clock and frame sync, which arrive as plain inputs and are sampled by the block's system clock. Every sync pulse is sorted as long or short by counting how many bit-clock falling edges see it high. That verdict then sets when the following frame starts driving and when it lets go of the line.

Samples arrive on a parallel port with a load strobe. They are held in a staging register and copied into the outgoing word at the sync rising edge. A wide format of 16 bits repeats the sign bit. A power-up input releases the line at once when low. After it rises, the line stays undriven for two frame periods before data is sent.

Top module: `pcm_tx_serializer`

## Requirements
- R1: A sync pulse is long when it is high on two or more consecutive bit-clock falling edges and short when it is high on exactly one.
- R2: Data bits change only on bit-clock rising edges, sign bit first, 13 bits per word in the standard format, each bit stable across the falling edge that follows it.
- R3: When the previous pulse was short, the sign bit is driven from the rising edge after the falling edge that saw the sync high, and the line is released at the falling edge in the middle of the last bit.
- R4: When the previous pulse was long, the sign bit is driven from the sync rising edge. The line is released at the later of the sync falling edge and the falling edge in the middle of the last bit, holding the last bit meanwhile.
- R5: The timing of each frame follows the type of the pulse before it, and a long pulse may change its length from frame to frame.
- R6: With the wide-format input high at the sync rising edge, the word is 16 bits: the sign bit four times, then sample bits 11 down to 0.
- R7: While the power-up input is low the line is released within one clock. After reset or power-up, the first two sync rising edges start no data, and the third does.
- R8: The sample is copied into the outgoing word at the sync rising edge, so a load during shifting affects only the next frame.
- R9: A frame whose sync rising edge saw no load since the previous one sends the value 0.
- R10: After reset the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| fsync_i | input | 1 | Frame sync |
| sample_i | input | SAMPLE_W | Signed parallel sample |
| load_i | input | 1 | Strobe that stages sample_i |
| pwr_up_i | input | 1 | High to operate, low to release the line |
| sext_mode_i | input | 1 | High selects the 16-bit sign-repeated word |
| sdata_o | output | 1 | Serial data, 0 while not enabled |
| sdata_oe_o | output | 1 | High while the line is driven |

## Verification
The bench records enable and data at every bit-clock falling edge. It compares them with a frame model that tracks the previous pulse type itself. The patterns are one-edge pulses, long pulses of two and three edges, and a pulse held past the last bit. These show the two start positions apart and show a release on the last bit apart from a release on the sync. Sign-negative and positive values, in both word formats, show sign repetition apart from zero fill. Frames without a load, with a load in mid-word, and with power dropped or restored show fresh data apart from stale data, and the guard frames apart from normal frames.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_PRE   = 3'd2,
        ST_SHIFT = 3'd3,
        ST_TAIL  = 3'd4
    } tx_state_e;
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } es_t;

    es_t d, q;

    always_comb begin
        d.sh   = {q.sh[STAGES-2:0], din};
        d.prev = q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign level_o = q.sh[STAGES-1];
    assign rise_o  = q.sh[STAGES-1] & ~q.prev;
    assign fall_o  = ~q.sh[STAGES-1] & q.prev;
endmodule

// File: rtl/pcm_sync_class.sv
module pcm_sync_class (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_level,
    input  logic fs_rise,
    input  logic fs_fall,
    input  logic bclk_fall,
    output logic prev_long_o
);
    typedef struct packed {
        logic [1:0] hits;
        logic       prev_long;
    } cl_t;

    cl_t d, q;

    always_comb begin
        d = q;
        if (fs_rise) begin
            d.hits = 2'd0;
        end else if (bclk_fall && fs_level && q.hits != 2'd2) begin
            d.hits = q.hits + 2'd1;
        end
        if (fs_fall) begin
            if (q.hits == 2'd2)      d.prev_long = 1'b1;
            else if (q.hits == 2'd1) d.prev_long = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign prev_long_o = q.prev_long;
endmodule

// File: rtl/pcm_word_fmt.sv
module pcm_word_fmt #(
    parameter int SAMPLE_W = 13,
    parameter int EXT_BITS = 3
) (
    input  logic [SAMPLE_W-1:0]                          word_i,
    input  logic                                         sext_i,
    output logic [SAMPLE_W+EXT_BITS-1:0]                 vec_o,
    output logic [$clog2(SAMPLE_W+EXT_BITS+1)-1:0]       last_o
);
    localparam int WORD_W = SAMPLE_W + EXT_BITS;
    localparam int IDX_W  = $clog2(WORD_W + 1);

    always_comb begin
        if (sext_i) begin
            vec_o  = {{EXT_BITS{word_i[SAMPLE_W-1]}}, word_i};
            last_o = IDX_W'(WORD_W - 1);
        end else begin
            vec_o  = {word_i, {EXT_BITS{1'b0}}};
            last_o = IDX_W'(SAMPLE_W - 1);
        end
    end
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer
    import pcm_tx_pkg::*;
#(
    parameter int SAMPLE_W     = 13,
    parameter int EXT_BITS     = 3,
    parameter int SYNC_STAGES  = 2,
    parameter int GUARD_FRAMES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                fsync_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                load_i,
    input  logic                pwr_up_i,
    input  logic                sext_mode_i,
    output logic                sdata_o,
    output logic                sdata_oe_o
);
    localparam int WORD_W = SAMPLE_W + EXT_BITS;
    localparam int IDX_W  = $clog2(WORD_W + 1);
    localparam int GW     = $clog2(GUARD_FRAMES + 1);

    // index 0: bit clock, index 1: frame sync
    logic [1:0] raw_in, lvl, rse, fll;
    assign raw_in = {fsync_i, bclk_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        pcm_edge_sync #(.STAGES(SYNC_STAGES)) i_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (raw_in[g]),
            .level_o (lvl[g]),
            .rise_o  (rse[g]),
            .fall_o  (fll[g])
        );
    end

    logic bclk_rise, bclk_fall, fs_level, fs_rise, fs_fall;
    assign bclk_rise = rse[0];
    assign bclk_fall = fll[0];
    assign fs_level  = lvl[1];
    assign fs_rise   = rse[1];
    assign fs_fall   = fll[1];

    logic prev_long;
    pcm_sync_class i_class (
        .clk         (clk),
        .rst_n       (rst_n),
        .fs_level    (fs_level),
        .fs_rise     (fs_rise),
        .fs_fall     (fs_fall),
        .bclk_fall   (bclk_fall),
        .prev_long_o (prev_long)
    );

    typedef struct packed {
        tx_state_e           st;
        logic [IDX_W-1:0]    idx;
        logic                half;
        logic                long_f;
        logic [SAMPLE_W-1:0] stage;
        logic                fresh;
        logic [SAMPLE_W-1:0] word;
        logic                sext;
        logic [GW-1:0]       guard;
    } tx_t;

    tx_t d, q;

    logic [WORD_W-1:0] vec;
    logic [IDX_W-1:0]  last_idx;
    logic [WORD_W-1:0] shifted;
    logic              guard_full;

    pcm_word_fmt #(.SAMPLE_W(SAMPLE_W), .EXT_BITS(EXT_BITS)) i_fmt (
        .word_i (q.word),
        .sext_i (q.sext),
        .vec_o  (vec),
        .last_o (last_idx)
    );

    assign guard_full = (q.guard == GW'(GUARD_FRAMES));

    always_comb begin
        d = q;
        if (load_i) begin
            d.stage = sample_i;
            d.fresh = 1'b1;
        end
        if (fs_rise) begin
            d.word  = q.fresh ? q.stage : '0;
            d.fresh = load_i;
            d.sext  = sext_mode_i;
            d.idx   = '0;
            d.half  = 1'b0;
            if (guard_full) begin
                d.long_f = prev_long;
                d.st     = prev_long ? ST_SHIFT : ST_ARM;
            end else begin
                d.guard = q.guard + 1'b1;
                d.st    = ST_IDLE;
            end
        end else begin
            case (q.st)
                ST_ARM: begin
                    if (bclk_fall && fs_level) d.st = ST_PRE;
                end
                ST_PRE: begin
                    if (bclk_rise) d.st = ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (bclk_fall) begin
                        d.half = 1'b1;
                        if (q.idx == last_idx) begin
                            d.st = (q.long_f && fs_level) ? ST_TAIL : ST_IDLE;
                        end
                    end else if (bclk_rise && q.half) begin
                        d.idx  = q.idx + 1'b1;
                        d.half = 1'b0;
                    end
                end
                ST_TAIL: begin
                    if (!fs_level) d.st = ST_IDLE;
                end
                default: d.st = ST_IDLE;
            endcase
        end
        if (!pwr_up_i) begin
            d.st    = ST_IDLE;
            d.guard = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign shifted    = vec << q.idx;
    assign sdata_oe_o = (q.st == ST_SHIFT) || (q.st == ST_TAIL);
    assign sdata_o    = sdata_oe_o & shifted[WORD_W-1];
endmodule

// File: rtl/pcm_tx_checker.sv
module pcm_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic pwr_up_i,
    input logic sdata_o,
    input logic sdata_oe_o,
    input logic bclk_rise,
    input logic bclk_fall,
    input logic fs_rise,
    input logic fs_fall,
    input logic guard_full
);
    AST_OFF_WHEN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_up_i |=> !sdata_oe_o); // R7

    AST_GUARD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_oe_o |-> guard_full); // R7

    AST_BIT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_oe_o && $past(sdata_oe_o) && !$stable(sdata_o)) |-> $past(bclk_rise || fs_rise)); // R2

    AST_DRIVE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe_o) |-> $past(bclk_rise || fs_rise)); // R3

    AST_DRIVE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdata_oe_o) |-> $past(bclk_fall || fs_fall || !pwr_up_i)); // R4
endmodule

bind pcm_tx_serializer pcm_tx_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_up_i   (pwr_up_i),
    .sdata_o    (sdata_o),
    .sdata_oe_o (sdata_oe_o),
    .bclk_rise  (bclk_rise),
    .bclk_fall  (bclk_fall),
    .fs_rise    (fs_rise),
    .fs_fall    (fs_fall),
    .guard_full (guard_full)
);

// File: tb/test_pcm_tx_serializer.sv
`timescale 1ns/1ps
module test_pcm_tx_serializer;
    localparam int H  = 8;
    localparam int NB = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_i = 1'b0;
    logic        fsync_i = 1'b0;
    logic [12:0] sample_i = '0;
    logic        load_i = 1'b0;
    logic        pwr_up_i = 1'b1;
    logic        sext_mode_i = 1'b0;
    logic        sdata_o, sdata_oe_o;

    int total = 0;
    int bad   = 0;
    bit obs_oe [NB];
    bit obs_d  [NB];
    bit bprev  = 1'b0;
    int bguard = 0;

    always #4 clk = ~clk;

    pcm_tx_serializer i_pcm_tx_serializer (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .fsync_i(fsync_i),
        .sample_i(sample_i), .load_i(load_i), .pwr_up_i(pwr_up_i),
        .sext_mode_i(sext_mode_i), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o)
    );

    task automatic pulse_load(input logic [12:0] v);
        @(negedge clk); sample_i = v; load_i = 1'b1;
        @(negedge clk); load_i = 1'b0;
    endtask

    // One frame of NB bit clocks; samples taken just before each falling edge.
    task automatic run_frame(input int fs_len, input bit do_load, input logic [12:0] val,
                             input bit sx, input int mid_at, input logic [12:0] mid_val,
                             input int pd_at);
        if (do_load) pulse_load(val);
        sext_mode_i = sx;
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            bclk_i  = 1'b1;
            fsync_i = (i < fs_len);
            if (i == pd_at) pwr_up_i = 1'b0;
            if (i == mid_at) begin sample_i = mid_val; load_i = 1'b1; end
            repeat (H) begin @(negedge clk); load_i = 1'b0; end
            obs_oe[i] = sdata_oe_o;
            obs_d[i]  = sdata_o;
            bclk_i = 1'b0;
            repeat (H) @(negedge clk);
        end
    endtask

    // Compares the recorded frame with the model and updates the model's state.
    task automatic check_frame(input string rq, input logic [12:0] v, input bit sx,
                               input int fs_len, input int pd_at);
        bit drive, lng, oe_e, d_e, oe_ok, d_ok;
        int start, len, j, bad_i;
        logic [15:0] vec;
        drive = (bguard == 2);
        if (!drive) bguard++;
        lng   = bprev;
        start = lng ? 0 : 1;
        len   = sx ? 16 : 13;
        vec   = sx ? {{3{v[12]}}, v} : {v, 3'b000};
        oe_ok = 1'b1; d_ok = 1'b1; bad_i = -1;
        for (int i = 0; i < NB; i++) begin
            oe_e = drive && ((i >= start && i < start + len) || (lng && i < fs_len));
            if (pd_at >= 0 && i >= pd_at) oe_e = 1'b0;
            if (obs_oe[i] !== oe_e) begin
                if (oe_ok) $display("FAIL %s enable at bit %0d: got %0b expected %0b", rq, i, obs_oe[i], oe_e);
                oe_ok = 1'b0;
            end
            j = i - start;
            if (oe_e && j >= 0 && j < len) begin
                d_e = vec[15-j];
                if (obs_d[i] !== d_e && d_ok) begin
                    $display("FAIL %s data at bit %0d: got %0b expected %0b (word %h)", rq, i, obs_d[i], d_e, v);
                    d_ok = 1'b0; bad_i = i;
                end
            end
        end
        total += 2;
        if (!oe_ok) bad++;
        if (!d_ok) bad++;
        if (fs_len >= 2) bprev = 1'b1;
        else if (fs_len == 1) bprev = 1'b0;
        if (pd_at >= 0) bguard = 0;
    endtask

    task automatic t_reset;
        total++;
        if (sdata_oe_o !== 1'b0) begin
            bad++;
            $display("FAIL R10 enable after reset: got %0b expected 0", sdata_oe_o);
        end
    endtask

    task automatic t_guard_after_reset;
        run_frame(1, 1, 13'h1A5B, 0, -1, 0, -1); check_frame("R7 guard frame 1", 13'h1A5B, 0, 1, -1);
        run_frame(1, 1, 13'h1A5B, 0, -1, 0, -1); check_frame("R7 guard frame 2", 13'h1A5B, 0, 1, -1);
        run_frame(1, 1, 13'h1A5B, 0, -1, 0, -1); check_frame("R3 short negative", 13'h1A5B, 0, 1, -1);
    endtask

    task automatic t_short;
        run_frame(1, 1, 13'h0123, 0, -1, 0, -1); check_frame("R2 short positive", 13'h0123, 0, 1, -1);
        run_frame(1, 1, 13'h1555, 0, -1, 0, -1); check_frame("R3 short alternating", 13'h1555, 0, 1, -1);
    endtask

    task automatic t_long;
        // first long pulse still follows the short one before it
        run_frame(3, 1, 13'h0F0F, 0, -1, 0, -1); check_frame("R5 previous short governs", 13'h0F0F, 0, 3, -1);
        run_frame(2, 1, 13'h10F1, 0, -1, 0, -1); check_frame("R1 two-edge pulse is long", 13'h10F1, 0, 2, -1);
        run_frame(3, 1, 13'h0AAA, 0, -1, 0, -1); check_frame("R4 long start", 13'h0AAA, 0, 3, -1);
    endtask

    task automatic t_tail;
        run_frame(18, 1, 13'h0001, 0, -1, 0, -1); check_frame("R4 release on sync fall", 13'h0001, 0, 18, -1);
        run_frame(1, 1, 13'h1FFE, 0, -1, 0, -1); check_frame("R5 long after held pulse", 13'h1FFE, 0, 1, -1);
        run_frame(1, 1, 13'h0246, 0, -1, 0, -1); check_frame("R1 one-edge pulse is short", 13'h0246, 0, 1, -1);
    endtask

    task automatic t_sext;
        run_frame(1, 1, 13'h1234, 1, -1, 0, -1); check_frame("R6 wide short negative", 13'h1234, 1, 1, -1);
        run_frame(2, 1, 13'h0567, 1, -1, 0, -1); check_frame("R6 wide short positive", 13'h0567, 1, 2, -1);
        run_frame(3, 1, 13'h1001, 1, -1, 0, -1); check_frame("R6 wide long negative", 13'h1001, 1, 3, -1);
    endtask

    task automatic t_no_load;
        run_frame(3, 0, 13'h0, 0, -1, 0, -1); check_frame("R9 no load sends zero", 13'h0000, 0, 3, -1);
    endtask

    task automatic t_inflight;
        run_frame(3, 1, 13'h0C3C, 0, 6, 13'h13C3, -1); check_frame("R8 word held in flight", 13'h0C3C, 0, 3, -1);
        run_frame(3, 0, 13'h0, 0, -1, 0, -1); check_frame("R8 mid-frame load sent next", 13'h13C3, 0, 3, -1);
    endtask

    task automatic t_power;
        run_frame(3, 1, 13'h0777, 0, -1, 0, 5); check_frame("R7 power down releases", 13'h0777, 0, 3, 5);
        @(negedge clk); pwr_up_i = 1'b1;
        run_frame(3, 1, 13'h0777, 0, -1, 0, -1); check_frame("R7 guard after power-up 1", 13'h0777, 0, 3, -1);
        run_frame(3, 1, 13'h0777, 0, -1, 0, -1); check_frame("R7 guard after power-up 2", 13'h0777, 0, 3, -1);
        run_frame(3, 1, 13'h0777, 0, -1, 0, -1); check_frame("R7 drive after guard", 13'h0777, 0, 3, -1);
    endtask

    initial begin
        #(200000 * 8);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_guard_after_reset();
        t_short();
        t_long();
        t_tail();
        t_sext();
        t_no_load();
        t_inflight();
        t_power();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule